// File: doc/BRIEF.md
# Two-Port Column-Scan Window Read Sequencer

This block drives the two read ports of one segment memory that holds a 32-row by 128-pixel band of an 8-bit image. It runs on a fast clock that is four times the rate of the filter's system clock. In each group of four fast cycles it reads one column of eight stacked pixels. The first port reads the even row offsets of the current row set and the second port reads the odd offsets. The eight pixels are packed into one output word together with a mask that marks the seven pixels that belong to a 7-row window. That word then stays constant for the whole system cycle, so seven one-dimensional filters can each take one slot.

Every row set of eight rows is scanned from left to right twice. On the second pass the port halves are exchanged in the output word and the mask names a different dead slot, so the seven-row window moves down by one row. After the second pass the set moves down by two rows, and the scan continues until the last set that fits inside the segment. The memory's output register adds read latency. The block carries the column's phase and pass tags alongside the returning data so that the swap and the mask stay aligned with that latency.

Top module: `colscan_seq`

## Requirements
- R1: After reset, busy, done, rdEn and outStb are 0 and winPix is all zero.
- R2: A start pulse is accepted only while busy is 0. Accepting it raises busy and clears done. A start pulse while busy is 1 leaves the output sequence unchanged.
- R3: In fast cycle k after acceptance (k from 0), rdEn is 1. For that cycle, let p = k mod 4, c the column and s the set. Then addrA = (2s+2p)*128 + c and addrB = addrA + 128. Both addresses stay below 32*128.
- R4: Columns run from 0 to 127 within a pass. Each set is read in pass 0 and then in pass 1. Set s starts at row 2s, for s from 0 to 12.
- R5: In pass 0, the port-A pixel from phase p goes to slot p and the port-B pixel goes to slot 4+p. Slot j occupies winPix bits [8j+7:8j].
- R6: In pass 1 the halves are swapped: the port-A pixel from phase p goes to slot 4+p and the port-B pixel goes to slot p.
- R7: winValid is 8'h7F for a pass-0 word (slot 7 is dead) and 8'hEF for a pass-1 word (slot 4 is dead).
- R8: outStb is a one-cycle pulse that marks a new word. During a scan the pulses are exactly 4 fast cycles apart, and winPix does not change between pulses.
- R9: The first word is loaded on the (4+READ_LAT)-th clock edge after the edge that accepts start, so outStb is first seen 5+READ_LAT cycles after the start cycle (7 with READ_LAT = 2).
- R10: done rises in the same cycle as the final outStb, and busy falls in that cycle. Both then hold, with rdEn 0 and winPix frozen, until the next accepted start.
- R11: One scan delivers exactly 2*128*13 = 3328 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the system clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan of the segment |
| dataA | input | 8 | Port-A read data, valid READ_LAT cycles after its address |
| dataB | input | 8 | Port-B read data, valid READ_LAT cycles after its address |
| rdEn | output | 1 | Both read ports are issuing this cycle |
| addrA | output | 12 | Port-A read address (row*128 + column) |
| addrB | output | 12 | Port-B read address |
| winPix | output | 64 | Eight packed window slots |
| winValid | output | 8 | Mask of the slots that hold window pixels |
| outStb | output | 1 | New output word this cycle |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | The last word of the scan has been delivered |

## Verification
Two functions can land in the same cycle. In one, the addresses for a new pass or a new set are issued while the previous pass's final column is still returning through the read latency. In the other, the word that finishes a pass is loaded while the swap and mask state has already changed at the issue side. The bench provokes this at every pass and set boundary with a latency-accurate memory model. It predicts each word's slots and mask from its index alone, so a word that used the wrong pass tag, or one that was dropped or duplicated, shows up as a mismatch or as a wrong gap.

// File: rtl/colscan_pkg.sv
package colscan_pkg;

  // fixed architecture: two ports, four reads each per system cycle
  localparam int PIX_PER_PORT = 4;
  localparam int SLOTS        = 2 * PIX_PER_PORT;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_DRAIN = 2'd2
  } scan_state_t;

  // strobes issued with each read pair, delayed alongside the data
  typedef struct packed {
    logic       issue;
    logic [1:0] phase;
    logic       pass;
    logic       last;
  } read_tag_t;

endpackage

// File: rtl/colscan_ctrl.sv
module colscan_ctrl
  import colscan_pkg::*;
#(
  parameter int WIDTH  = 128,
  parameter int ROWS   = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              finalLoad,
  output logic              startAcc,
  output read_tag_t         tag,
  output logic              rdEn,
  output logic [ADDR_W-1:0] addrA,
  output logic [ADDR_W-1:0] addrB,
  output logic              busy
);

  localparam int NSETS = (ROWS - SLOTS) / 2 + 1;
  localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1;
  localparam int COL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int ROW_W = $clog2(ROWS);

  scan_state_t      stateQ;
  logic [1:0]       phaseQ;
  logic [COL_W-1:0] colQ;
  logic             passQ;
  logic [SET_W-1:0] setQ;

  logic             lastPhase, lastCol, lastSet;
  logic [ROW_W-1:0] rowA, rowB;

  assign lastPhase = (phaseQ == 2'd3);
  assign lastCol   = (colQ == COL_W'(WIDTH - 1));
  assign lastSet   = (setQ == SET_W'(NSETS - 1));

  assign startAcc  = start && (stateQ == ST_IDLE);
  assign rdEn      = (stateQ == ST_SCAN);
  assign busy      = (stateQ != ST_IDLE);

  // even offsets on port A, the odd row just below on port B
  assign rowA = ROW_W'({setQ, 1'b0}) + ROW_W'({phaseQ, 1'b0});
  assign rowB = rowA + ROW_W'(1);

  always_comb begin
    addrA = '0;
    addrB = '0;
    if (rdEn) begin
      addrA = ADDR_W'(rowA) * ADDR_W'(WIDTH) + ADDR_W'(colQ);
      addrB = ADDR_W'(rowB) * ADDR_W'(WIDTH) + ADDR_W'(colQ);
    end
  end

  always_comb begin
    tag.issue = rdEn;
    tag.phase = phaseQ;
    tag.pass  = passQ;
    tag.last  = rdEn && lastPhase && lastCol && passQ && lastSet;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ <= ST_IDLE;
      phaseQ <= '0;
      colQ   <= '0;
      passQ  <= 1'b0;
      setQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (start) begin
            stateQ <= ST_SCAN;
            phaseQ <= '0;
            colQ   <= '0;
            passQ  <= 1'b0;
            setQ   <= '0;
          end
        end
        ST_SCAN: begin
          phaseQ <= phaseQ + 2'd1;
          if (lastPhase) begin
            if (lastCol) begin
              colQ <= '0;
              if (passQ) begin
                passQ <= 1'b0;
                if (lastSet) stateQ <= ST_DRAIN;
                else         setQ   <= setQ + SET_W'(1);
              end else begin
                passQ <= 1'b1;
              end
            end else begin
              colQ <= colQ + COL_W'(1);
            end
          end
        end
        ST_DRAIN: begin
          if (finalLoad) stateQ <= ST_IDLE;
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/colscan_dpath.sv
module colscan_dpath
  import colscan_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int READ_LAT = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  read_tag_t              tag,
  input  logic                   startAcc,
  input  logic [PIX_W-1:0]       dataA,
  input  logic [PIX_W-1:0]       dataB,
  output logic [SLOTS*PIX_W-1:0] winPix,
  output logic [SLOTS-1:0]       winValid,
  output logic                   outStb,
  output logic                   done,
  output logic                   finalLoad
);

  localparam int WORD_W = SLOTS * PIX_W;
  localparam logic [SLOTS-1:0] MASK_P0 = 8'h7F;
  localparam logic [SLOTS-1:0] MASK_P1 = 8'hEF;

  read_tag_t tagPipe [READ_LAT];
  read_tag_t dTag;

  logic [WORD_W-1:0] stageQ, stageD;
  logic [2:0]        slotA, slotB;
  logic              loadNow;

  // tag delay line matches the memory read latency
  generate
    for (genvar i = 0; i < READ_LAT; i++) begin : g_tag
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) tagPipe[0] <= '0;
          else     tagPipe[0] <= tag;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) tagPipe[i] <= '0;
          else     tagPipe[i] <= tagPipe[i-1];
        end
      end
    end
  endgenerate

  assign dTag      = tagPipe[READ_LAT-1];
  assign slotA     = {dTag.pass, dTag.phase};
  assign slotB     = {~dTag.pass, dTag.phase};
  assign loadNow   = dTag.issue && (dTag.phase == 2'd3);
  assign finalLoad = loadNow && dTag.last;

  always_comb begin
    stageD = stageQ;
    if (dTag.issue) begin
      stageD[int'(slotA)*PIX_W +: PIX_W] = dataA;
      stageD[int'(slotB)*PIX_W +: PIX_W] = dataB;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stageQ   <= '0;
      winPix   <= '0;
      winValid <= '0;
      outStb   <= 1'b0;
      done     <= 1'b0;
    end else begin
      stageQ <= stageD;
      outStb <= loadNow;
      if (loadNow) begin
        winPix   <= stageD;
        winValid <= dTag.pass ? MASK_P1 : MASK_P0;
      end
      if (startAcc)       done <= 1'b0;
      else if (finalLoad) done <= 1'b1;
    end
  end

endmodule

// File: rtl/colscan_seq.sv
module colscan_seq
  import colscan_pkg::*;
#(
  parameter int WIDTH    = 128,
  parameter int ROWS     = 32,
  parameter int PIX_W    = 8,
  parameter int READ_LAT = 2,
  parameter int ADDR_W   = $clog2(ROWS * WIDTH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [PIX_W-1:0]       dataA,
  input  logic [PIX_W-1:0]       dataB,
  output logic                   rdEn,
  output logic [ADDR_W-1:0]      addrA,
  output logic [ADDR_W-1:0]      addrB,
  output logic [SLOTS*PIX_W-1:0] winPix,
  output logic [SLOTS-1:0]       winValid,
  output logic                   outStb,
  output logic                   busy,
  output logic                   done
);

  read_tag_t tag;
  logic      startAcc;
  logic      finalLoad;

  colscan_ctrl #(
    .WIDTH (WIDTH),
    .ROWS  (ROWS),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .finalLoad(finalLoad),
    .startAcc (startAcc),
    .tag      (tag),
    .rdEn     (rdEn),
    .addrA    (addrA),
    .addrB    (addrB),
    .busy     (busy)
  );

  colscan_dpath #(
    .PIX_W   (PIX_W),
    .READ_LAT(READ_LAT)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .tag      (tag),
    .startAcc (startAcc),
    .dataA    (dataA),
    .dataB    (dataB),
    .winPix   (winPix),
    .winValid (winValid),
    .outStb   (outStb),
    .done     (done),
    .finalLoad(finalLoad)
  );

endmodule

// File: rtl/colscan_seq_chk.sv
module colscan_seq_chk #(
  parameter int WIDTH  = 128,
  parameter int ROWS   = 32,
  parameter int ADDR_W = 12,
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addrA,
  input logic [ADDR_W-1:0] addrB,
  input logic [WORD_W-1:0] winPix,
  input logic [7:0]        winValid,
  input logic              outStb,
  input logic              busy,
  input logic              done
);

  // R3: port B always reads the row just below port A, same column
  assert_addr_pair_R3: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> (32'(addrB) == 32'(addrA) + WIDTH));

  // R3: addresses stay inside the segment
  assert_addr_range_R3: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> (32'(addrB) < ROWS * WIDTH));

  // R2: reads are issued only during a scan
  assert_issue_busy_R2: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> busy);

  // R7: every word carries exactly one of the two seven-slot masks
  assert_mask_shape_R7: assert property (@(posedge clk) disable iff (rst)
    outStb |-> (($countones(winValid) == 7) &&
                (winValid == 8'h7F || winValid == 8'hEF)));

  // R8: strobe is a single-cycle pulse
  assert_stb_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    outStb |=> !outStb);

  // R8: word held between strobes
  assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !outStb |-> $stable(winPix));

  // R10: done and busy are never both high
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind colscan_seq colscan_seq_chk #(
  .WIDTH (WIDTH),
  .ROWS  (ROWS),
  .ADDR_W(ADDR_W),
  .WORD_W(colscan_pkg::SLOTS * PIX_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .rdEn    (rdEn),
  .addrA   (addrA),
  .addrB   (addrB),
  .winPix  (winPix),
  .winValid(winValid),
  .outStb  (outStb),
  .busy    (busy),
  .done    (done)
);

// File: tb/colscan_seq_test.sv
`timescale 1ns/1ps
module colscan_seq_test;

  localparam int W     = 128;
  localparam int ROWS  = 32;
  localparam int LAT   = 2;
  localparam int AW    = 12;
  localparam int NSETS = (ROWS - 8) / 2 + 1;
  localparam int TOTAL = 2 * W * NSETS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [7:0]    dataA, dataB;
  logic          rdEn, outStb, busy, done;
  logic [AW-1:0] addrA, addrB;
  logic [63:0]   winPix;
  logic [7:0]    winValid;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // monitor state
  bit monOn = 1'b0;
  int widx = 0;
  int prevStb = -1;

  always #10 clk = ~clk;

  colscan_seq #(.WIDTH(W), .ROWS(ROWS), .PIX_W(8), .READ_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .start(start), .dataA(dataA), .dataB(dataB),
    .rdEn(rdEn), .addrA(addrA), .addrB(addrB), .winPix(winPix),
    .winValid(winValid), .outStb(outStb), .busy(busy), .done(done));

  function automatic logic [7:0] pixOf(int a);
    return 8'((a * 37) ^ (a >> 7));
  endfunction

  // memory model: data appears LAT cycles after its address
  logic [7:0] pipeA [LAT];
  logic [7:0] pipeB [LAT];
  always @(posedge clk) begin
    pipeA[0] <= pixOf(int'(addrA));
    pipeB[0] <= pixOf(int'(addrB));
    for (int i = 1; i < LAT; i++) begin
      pipeA[i] <= pipeA[i-1];
      pipeB[i] <= pipeB[i-1];
    end
  end
  assign dataA = pipeA[LAT-1];
  assign dataB = pipeB[LAT-1];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] expWord(int k);
    logic [63:0] w;
    int s, ps, c;
    s  = k / (2 * W);
    ps = (k / W) % 2;
    c  = k % W;
    w  = '0;
    for (int p = 0; p < 4; p++) begin
      int ra, sa, sb;
      ra = 2 * s + 2 * p;
      sa = ps ? 4 + p : p;
      sb = ps ? p : 4 + p;
      w[sa*8 +: 8] = pixOf(ra * W + c);
      w[sb*8 +: 8] = pixOf((ra + 1) * W + c);
    end
    return w;
  endfunction

  // word monitor: R4/R5/R6 content, R7 mask, R8 spacing, R10 final
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (monOn && outStb) begin
      int ps;
      ps = (widx / W) % 2;
      if (widx < TOTAL) begin
        check(winPix == expWord(widx), ps ? "R6" : "R5", "word content R4",
              winPix, expWord(widx));
        check(winValid == (ps ? 8'hEF : 8'h7F), "R7", "mask",
              winValid, ps ? 8'hEF : 8'h7F);
      end else begin
        check(1'b0, "R11", "extra word", widx, TOTAL - 1);
      end
      if (prevStb >= 0) check(cyc - prevStb == 4, "R8", "strobe gap", cyc - prevStb, 4);
      if (widx == TOTAL - 1) check(done && !busy, "R10", "done with last word",
                                   {done, busy}, 2'b10);
      prevStb = cyc;
      widx++;
    end
  end

  task automatic test_reset();
    check(!busy && !done && !rdEn && !outStb, "R1", "control outputs",
          {busy, done, rdEn, outStb}, 0);
    check(winPix == '0, "R1", "winPix", winPix, 0);
  endtask

  task automatic start_scan();
    widx = 0;
    prevStb = -1;
    monOn = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // R3 addresses and R9 first-word latency
  task automatic test_first_word();
    int n;
    start_scan();
    n = 1;
    check(busy && !done, "R2", "start accepted", {busy, done}, 2'b10);
    for (int k = 0; k < 6; k++) begin
      int p, c, ea;
      p = k % 4;
      c = k / 4;
      ea = 2 * p * W + c;
      check(rdEn == 1'b1, "R3", "rdEn", rdEn, 1);
      check(int'(addrA) == ea, "R3", "addrA", addrA, ea);
      check(int'(addrB) == ea + W, "R3", "addrB", addrB, ea + W);
      if (outStb) break;
      @(negedge clk);
      n++;
    end
    while (!outStb && n < 50) begin
      @(negedge clk);
      n++;
    end
    check(n == 5 + LAT, "R9", "first strobe latency", n, 5 + LAT);
  endtask

  task automatic wait_done(bit pokeStart);
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (pokeStart && n == 1000) begin
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy && !done, "R2", "start ignored while busy", {busy, done}, 2'b10);
      end
    end
    @(negedge clk);
    check(widx == TOTAL, "R11", "word count", widx, TOTAL);
    check(done && !busy, "R10", "final state", {done, busy}, 2'b10);
  endtask

  task automatic test_done_hold();
    logic [63:0] held;
    held = winPix;
    monOn = 1'b0;
    repeat (16) @(negedge clk);
    check(done && !busy && !rdEn && !outStb, "R10", "idle after done",
          {done, busy, rdEn, outStb}, 4'b1000);
    check(winPix == held, "R10", "winPix frozen", winPix, held);
  endtask

  task automatic test_restart();
    start_scan();
    check(!done && busy, "R2", "restart clears done", {done, busy}, 2'b01);
    wait_done(1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_first_word();
    wait_done(1'b1);
    test_done_hold();
    test_restart();
    test_done_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule